// File: doc/BRIEF.md
# Streaming Pixel Point-Transform Unit

This block applies a per-pixel intensity curve to a raster-scan video stream. Each clock it may accept one pixel, either a single grey sample on the red lane or a full red/green/blue triple, with a valid flag and a start-of-frame flag. The selected curve is applied to each colour lane on its own. The lanes have identical datapaths and do not interact. Every arithmetic result saturates to the 8-bit range.

The curve and its controls are mode, brighten/darken direction, grey-only flag, and the two window thresholds. They are taken from the configuration inputs only on a valid start-of-frame pixel, and they apply from that pixel onward. A single frame therefore never mixes settings, and the configuration inputs can change at any time without disturbing the frame in flight. The output is a valid-qualified pixel in the same format, three clocks after the input.

Top module: `pxt_point_xform`

## Requirements
- R1: A pixel presented in cycle t appears on the outputs in cycle t+3. `out_valid` repeats `in_valid` three cycles later, and `out_sof` repeats `in_valid && in_sof` three cycles later.
- R2: `cfg_mode`, `cfg_dim`, `cfg_gray`, `cfg_lo` and `cfg_hi` are captured only in a cycle where `in_valid` and `in_sof` are both high. The captured settings apply to that pixel and to all later pixels until the next capture. At any other time the configuration inputs have no effect on the outputs.
- R3: Mode code 0 passes each sample through unchanged.
- R4: Mode code 1 adds 90 to each sample and clamps at 255.
- R5: Mode code 2 adds 40 when `cfg_dim` is 0 and subtracts 40 when it is 1. The result clamps to the range 0..255.
- R6: Mode code 3 outputs 255 minus the sample, which is the bitwise inverse.
- R7: Mode code 4 applies the linear stretch `floor(((x-160)*2673 + 2048) / 4096) + 192`, clamped to 0..255. Here 2673/4096 is the 12-fraction-bit value of 62/95. Sample values: 0 maps to 88, 160 maps to 192, 255 maps to 254.
- R8: Mode code 5 outputs x when `cfg_lo < x < cfg_hi`, both comparisons strict, and outputs 1 otherwise.
- R9: Let b = floor((255*(x-128)^2 + 8192) / 16384), clamped to 255. Mode code 7 outputs b, a bowl with 128 mapping to 0. Mode code 6 outputs 255 minus b, a hump with 128 mapping to 255.
- R10: When the captured grey flag is set, `out_g` and `out_b` are 0 on every valid output, and `out_r` carries the transformed grey sample.
- R11: In colour operation the green and blue lanes follow the same curve as red, each computed only from its own input sample.
- R12: While `rst` is high, `out_valid` and `out_sof` fall low by the next clock. After reset the settings are mode 0, not dimming, colour, low threshold 0 and high threshold 255. These settings hold until the first capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel qualifier |
| in_sof | input | 1 | First pixel of a frame (used only with in_valid) |
| in_r | input | 8 | Red sample, or grey sample |
| in_g | input | 8 | Green sample |
| in_b | input | 8 | Blue sample |
| cfg_mode | input | 3 | Curve selector, captured at frame start |
| cfg_dim | input | 1 | Brightness direction: 1 darkens, 0 brightens |
| cfg_gray | input | 1 | Grey-only operation |
| cfg_lo | input | 8 | Lower window threshold (exclusive) |
| cfg_hi | input | 8 | Upper window threshold (exclusive) |
| out_valid | output | 1 | Output pixel qualifier |
| out_sof | output | 1 | First pixel of a frame, delayed |
| out_r | output | 8 | Transformed red or grey sample |
| out_g | output | 8 | Transformed green sample |
| out_b | output | 8 | Transformed blue sample |

## Verification
The assertions assume that `rst` is held high through at least one clock edge at the start of the run. They also assume that the inputs are known values whenever the block is out of reset.

Lane and latency properties look back three cycles. A guard counter keeps them from looking past the last reset. The frame-start properties also assume that a valid start-of-frame pixel is the only event that changes the held settings.

The stimulus keeps to these assumptions. It drives every input to a defined value on every cycle. It randomizes the configuration inputs freely, with start-of-frame pulses both with and without `in_valid`, so the capture rule is exercised as well as relied on.

// File: rtl/pxt_pkg.sv
package pxt_pkg;

   typedef enum logic [2:0] {
      PXT_PASS = 3'd0,
      PXT_ENH  = 3'd1,
      PXT_BRT  = 3'd2,
      PXT_NEG  = 3'd3,
      PXT_STR  = 3'd4,
      PXT_WIN  = 3'd5,
      PXT_HUMP = 3'd6,
      PXT_BOWL = 3'd7
   } pxt_mode_e;

   typedef struct packed {
      pxt_mode_e   mode;
      logic        dim;
      logic        gray;
      logic [7:0]  lo;
      logic [7:0]  hi;
   } pxt_cfg_t;

   localparam pxt_cfg_t PXT_CFG_RESET = '{mode: PXT_PASS, dim: 1'b0, gray: 1'b0,
                                          lo: 8'd0, hi: 8'd255};

   // clamp a signed intermediate into 0..maxv
   function automatic int pxt_clamp(input int v, input int maxv);
      if (v < 0)         return 0;
      else if (v > maxv) return maxv;
      else               return v;
   endfunction

endpackage

// File: rtl/pxt_cfg_hold.sv
module pxt_cfg_hold
   import pxt_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     take,
   input  pxt_cfg_t cfg_new,
   output pxt_cfg_t cfg_q
);

   always_ff @(posedge clk) begin
      if (rst)       cfg_q <= PXT_CFG_RESET;
      else if (take) cfg_q <= cfg_new;
   end

endmodule

// File: rtl/pxt_chan.sv
module pxt_chan
   import pxt_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int CH       = 0,
   parameter int ENH_ADD  = 90,
   parameter int BRT_STEP = 40,
   parameter int STR_LO   = 160,
   parameter int STR_BASE = 192,
   parameter int STR_NUM  = 62,
   parameter int STR_DEN  = 95,
   parameter int STR_FRAC = 12
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             v1,
   input  logic             v2,
   input  logic [PIX_W-1:0] px,
   input  pxt_cfg_t         cfg,
   output logic [PIX_W-1:0] px_out
);

   localparam int MAXV  = (1 << PIX_W) - 1;
   localparam int MID   = 1 << (PIX_W - 1);
   localparam int GAIN  = (STR_NUM * (1 << STR_FRAC) + STR_DEN / 2) / STR_DEN;
   localparam int SHALF = 1 << (STR_FRAC - 1);
   localparam int PSH   = 2 * (PIX_W - 1);
   localparam int PHALF = 1 << (PSH - 1);
   localparam int SW    = PIX_W + 3;
   localparam int PW    = STR_FRAC + PIX_W + 2;
   localparam int QW    = 2 * PIX_W;
   localparam bit SIDE  = (CH != 0);

   // ---------------- stage 2 : offsets, compares, multiplies
   int sum_i, str_i, sq_i;

   always_comb begin
      unique case (cfg.mode)
         PXT_ENH: sum_i = int'(px) + ENH_ADD;
         PXT_BRT: sum_i = cfg.dim ? int'(px) - BRT_STEP : int'(px) + BRT_STEP;
         PXT_NEG: sum_i = MAXV - int'(px);
         PXT_WIN: sum_i = (px > cfg.lo && px < cfg.hi) ? int'(px) : 1;
         default: sum_i = int'(px);
      endcase
      str_i = (int'(px) - STR_LO) * GAIN;
      sq_i  = (int'(px) - MID) * (int'(px) - MID);
   end

   logic signed [SW-1:0] sum_q;
   logic signed [PW-1:0] str_q;
   logic [QW-1:0]        sq_q;
   pxt_mode_e            mode_q;
   logic                 zero_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_q  <= '0;
         str_q  <= '0;
         sq_q   <= '0;
         mode_q <= PXT_PASS;
         zero_q <= 1'b0;
      end else if (v1) begin
         sum_q  <= SW'(sum_i);
         str_q  <= PW'(str_i);
         sq_q   <= QW'(sq_i);
         mode_q <= cfg.mode;
         zero_q <= SIDE && cfg.gray;
      end
   end

   // ---------------- stage 3 : rounding, selection, saturation
   int par_i, lin_i, res_i;

   always_comb begin
      par_i = pxt_clamp((int'(sq_q) * MAXV + PHALF) >>> PSH, MAXV);
      lin_i = ((int'(str_q) + SHALF) >>> STR_FRAC) + STR_BASE;
      unique case (mode_q)
         PXT_STR:  res_i = lin_i;
         PXT_HUMP: res_i = MAXV - par_i;
         PXT_BOWL: res_i = par_i;
         default:  res_i = int'(sum_q);
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)     px_out <= '0;
      else if (v2) px_out <= zero_q ? '0 : PIX_W'(pxt_clamp(res_i, MAXV));
   end

endmodule

// File: rtl/pxt_point_xform.sv
module pxt_point_xform
   import pxt_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int ENH_ADD  = 90,
   parameter int BRT_STEP = 40,
   parameter int STR_FRAC = 12
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic [PIX_W-1:0] in_r,
   input  logic [PIX_W-1:0] in_g,
   input  logic [PIX_W-1:0] in_b,
   input  logic [2:0]       cfg_mode,
   input  logic             cfg_dim,
   input  logic             cfg_gray,
   input  logic [7:0]       cfg_lo,
   input  logic [7:0]       cfg_hi,
   output logic             out_valid,
   output logic             out_sof,
   output logic [PIX_W-1:0] out_r,
   output logic [PIX_W-1:0] out_g,
   output logic [PIX_W-1:0] out_b
);

   localparam int NCH = 3;

   if (PIX_W != 8) begin : g_bad_width
      $error("pxt_point_xform: PIX_W must be 8");
   end
   if (STR_FRAC < 10 || STR_FRAC > 20) begin : g_bad_frac
      $error("pxt_point_xform: STR_FRAC must lie in 10..20");
   end

   // ---------------- frame-start capture of settings
   logic     take;
   pxt_cfg_t cfg_new, cfg_hold, cfg_eff;

   assign take    = in_valid && in_sof;
   assign cfg_new = '{mode: pxt_mode_e'(cfg_mode), dim: cfg_dim, gray: cfg_gray,
                      lo: cfg_lo, hi: cfg_hi};
   assign cfg_eff = take ? cfg_new : cfg_hold;

   pxt_cfg_hold u_cfg (
      .clk     (clk),
      .rst     (rst),
      .take    (take),
      .cfg_new (cfg_new),
      .cfg_q   (cfg_hold)
   );

   // ---------------- stage 1 : input register
   logic [NCH-1:0][PIX_W-1:0] px_in, px1_q, px3;
   pxt_cfg_t                  cfg1_q;
   logic                      v1_q, v2_q, s1_q, s2_q;

   assign px_in = {in_b, in_g, in_r};

   always_ff @(posedge clk) begin
      if (rst) begin
         v1_q   <= 1'b0;
         s1_q   <= 1'b0;
         px1_q  <= '0;
         cfg1_q <= PXT_CFG_RESET;
      end else begin
         v1_q <= in_valid;
         s1_q <= take;
         if (in_valid) begin
            px1_q  <= px_in;
            cfg1_q <= cfg_eff;
         end
      end
   end

   // ---------------- control delay line for stages 2 and 3
   always_ff @(posedge clk) begin
      if (rst) begin
         v2_q      <= 1'b0;
         s2_q      <= 1'b0;
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
      end else begin
         v2_q      <= v1_q;
         s2_q      <= s1_q;
         out_valid <= v2_q;
         out_sof   <= s2_q;
      end
   end

   // ---------------- per-lane datapaths
   for (genvar c = 0; c < NCH; c++) begin : g_lane
      pxt_chan #(
         .PIX_W    (PIX_W),
         .CH       (c),
         .ENH_ADD  (ENH_ADD),
         .BRT_STEP (BRT_STEP),
         .STR_FRAC (STR_FRAC)
      ) u_chan (
         .clk    (clk),
         .rst    (rst),
         .v1     (v1_q),
         .v2     (v2_q),
         .px     (px1_q[c]),
         .cfg    (cfg1_q),
         .px_out (px3[c])
      );
   end

   assign out_r = px3[0];
   assign out_g = px3[1];
   assign out_b = px3[2];

endmodule

// File: rtl/pxt_point_xform_chk.sv
module pxt_point_xform_chk
   import pxt_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic       in_valid,
   input logic       in_sof,
   input logic [7:0] in_r,
   input logic [7:0] in_g,
   input logic [2:0] cfg_mode,
   input logic       cfg_gray,
   input pxt_cfg_t   cfg_hold,
   input logic       out_valid,
   input logic       out_sof,
   input logic [7:0] out_r,
   input logic [7:0] out_g,
   input logic [7:0] out_b
);

   // cycles since reset, saturating at the pipeline depth
   logic [1:0] age;
   always_ff @(posedge clk) begin
      if (rst)            age <= 2'd0;
      else if (age != 3)  age <= age + 2'd1;
   end

   // R1: valid and frame-start delayed by exactly three clocks
   a_r1_valid_delay: assert property (@(posedge clk) disable iff (rst)
      age == 2'd3 |-> out_valid == $past(in_valid, 3));

   a_r1_sof_delay: assert property (@(posedge clk) disable iff (rst)
      age == 2'd3 |-> out_sof == $past(in_valid && in_sof, 3));

   // R2: held settings move only on a valid frame start
   a_r2_hold_settings: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && in_sof) |=> $stable(cfg_hold));

   // R6: a frame-start pixel in inversion mode comes out inverted
   a_r6_invert: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd3 && $past(in_valid && in_sof && cfg_mode == 3'd3 && !cfg_gray, 3))
      |-> (out_r == ~$past(in_r, 3) && out_g == ~$past(in_g, 3)));

   // R10: grey frames blank the side lanes
   a_r10_gray_blank: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd3 && $past(in_valid && in_sof && cfg_gray, 3))
      |-> (out_g == 8'd0 && out_b == 8'd0));

   // R12: reset clears the output qualifiers by the next edge
   a_r12_reset_idle: assert property (@(posedge clk)
      rst |=> (!out_valid && !out_sof));

endmodule

bind pxt_point_xform pxt_point_xform_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_sof    (in_sof),
   .in_r      (in_r),
   .in_g      (in_g),
   .cfg_mode  (cfg_mode),
   .cfg_gray  (cfg_gray),
   .cfg_hold  (cfg_hold),
   .out_valid (out_valid),
   .out_sof   (out_sof),
   .out_r     (out_r),
   .out_g     (out_g),
   .out_b     (out_b)
);

// File: tb/pxt_point_xform_bench.sv
module pxt_point_xform_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0, in_sof = 1'b0;
   logic [7:0] in_r = '0, in_g = '0, in_b = '0;
   logic [2:0] cfg_mode = '0;
   logic       cfg_dim = 1'b0, cfg_gray = 1'b0;
   logic [7:0] cfg_lo = '0, cfg_hi = '0;
   logic       out_valid, out_sof;
   logic [7:0] out_r, out_g, out_b;

   always #4 clk = ~clk;

   pxt_point_xform u_pxt_point_xform (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
      .in_r(in_r), .in_g(in_g), .in_b(in_b),
      .cfg_mode(cfg_mode), .cfg_dim(cfg_dim), .cfg_gray(cfg_gray),
      .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
      .out_valid(out_valid), .out_sof(out_sof),
      .out_r(out_r), .out_g(out_g), .out_b(out_b)
   );

   int total = 0, bad = 0, wd = 0, cyc = 0;
   bit done = 1'b0;

   // bench copy of the captured settings, built from R2 and R12
   int  m_mode = 0, m_dim = 0, m_gray = 0, m_lo = 0, m_hi = 255;
   bit  seen_sof = 1'b0;

   bit    ev[4], es[4], egray[4];
   int    ex[4][3];
   string et[4];

   function automatic int sat(input int v);
      return (v < 0) ? 0 : (v > 255) ? 255 : v;
   endfunction

   function automatic int bowl(input int p);
      return sat(((p - 128) * (p - 128) * 255 + 8192) >>> 14);
   endfunction

   function automatic int xf(input int mode, input int dim, input int lo,
                             input int hi, input int p);
      case (mode)
         1:       return sat(p + 90);
         2:       return dim ? sat(p - 40) : sat(p + 40);
         3:       return 255 - p;
         4:       return sat((((p - 160) * 2673 + 2048) >>> 12) + 192);
         5:       return (p > lo && p < hi) ? p : 1;
         6:       return 255 - bowl(p);
         7:       return bowl(p);
         default: return p;
      endcase
   endfunction

   function automatic string mtag(input int mode);
      case (mode)
         1: return "R4";
         2: return "R5";
         3: return "R6";
         4: return "R7";
         5: return "R8";
         6: return "R9";
         7: return "R9";
         default: return "R3";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // one cycle: check the slot due now, then model and drive the next input
   task automatic step(input bit v, input bit s, input int r, input int g,
                       input int b, input int mode, input int dim, input int gray,
                       input int lo, input int hi);
      int k, w;
      bit junk;
      @(negedge clk);
      k = (cyc + 1) % 4;
      chk(out_valid == ev[k], "R1", "valid", int'(out_valid), int'(ev[k]));
      chk(out_sof == es[k], "R1", "sof", int'(out_sof), int'(es[k]));
      if (ev[k] && out_valid) begin
         chk(int'(out_r) == ex[k][0], et[k], "red", int'(out_r), ex[k][0]);
         chk(int'(out_g) == ex[k][1], egray[k] ? "R10" : "R11", "green",
             int'(out_g), ex[k][1]);
         chk(int'(out_b) == ex[k][2], egray[k] ? "R10" : "R11", "blue",
             int'(out_b), ex[k][2]);
      end
      junk = (mode != m_mode) || (dim != m_dim) || (gray != m_gray) ||
             (lo != m_lo) || (hi != m_hi);
      if (v && s) begin
         m_mode = mode; m_dim = dim; m_gray = gray; m_lo = lo; m_hi = hi;
         seen_sof = 1'b1;
      end
      w = cyc % 4;
      ev[w]    = v;
      es[w]    = v && s;
      egray[w] = (m_gray != 0);
      ex[w][0] = xf(m_mode, m_dim, m_lo, m_hi, r);
      ex[w][1] = m_gray ? 0 : xf(m_mode, m_dim, m_lo, m_hi, g);
      ex[w][2] = m_gray ? 0 : xf(m_mode, m_dim, m_lo, m_hi, b);
      if (!seen_sof)          et[w] = "R12";
      else if (junk && !s)    et[w] = {mtag(m_mode), "+R2"};
      else                    et[w] = mtag(m_mode);
      in_valid = v;  in_sof = s;
      in_r = 8'(r);  in_g = 8'(g);  in_b = 8'(b);
      cfg_mode = 3'(mode); cfg_dim = dim[0]; cfg_gray = gray[0];
      cfg_lo = 8'(lo); cfg_hi = 8'(hi);
      cyc++;
   endtask

   function automatic int pick(input int i);
      int pts[16] = '{0, 1, 39, 40, 41, 89, 127, 128, 129, 160, 165, 166, 200, 216, 254, 255};
      return pts[i % 16];
   endfunction

   // directed frame over corner samples; settings inputs scrambled after start
   task automatic dir_frame(input int mode, input int dim, input int gray,
                            input int lo, input int hi);
      for (int i = 0; i < 16; i++) begin
         if (i == 0)
            step(1, 1, pick(i), pick(15 - i), pick(i + 5), mode, dim, gray, lo, hi);
         else
            step(1, 0, pick(i), pick(15 - i), pick(i + 5), (mode + i) % 8,
                 dim ^ (i & 1), gray ^ (i & 1), 255 - lo, 255 - hi);
         if (i % 4 == 1)  // frame start without valid must not capture (R2)
            step(0, 1, 7, 7, 7, (mode + 3) % 8, 1 - dim, 1 - gray, 3, 9);
      end
   endtask

   always @(posedge clk) begin
      if (!done) begin
         wd++;
         if (wd > 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 150000);
            finish_run();
         end
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < 4; i++) begin
         ev[i] = 1'b0; es[i] = 1'b0; egray[i] = 1'b0; et[i] = "R1";
         for (int c = 0; c < 3; c++) ex[i][c] = 0;
      end
      rst = 1'b1;
      repeat (4) @(negedge clk);
      chk(out_valid == 1'b0, "R12", "valid in reset", int'(out_valid), 0);
      chk(out_sof == 1'b0, "R12", "sof in reset", int'(out_sof), 0);
      rst = 1'b0;

      // R12: settings after reset are pass-through until a capture
      for (int i = 0; i < 6; i++)
         step(1, 0, pick(i * 3), pick(i * 3 + 1), pick(i * 3 + 2), 3, 1, 1, 9, 20);

      // directed sweeps over every curve
      dir_frame(0, 0, 0, 0, 255);   // R3
      dir_frame(1, 0, 0, 0, 255);   // R4
      dir_frame(2, 0, 0, 0, 255);   // R5 brighten
      dir_frame(2, 1, 0, 0, 255);   // R5 darken
      dir_frame(3, 0, 0, 0, 255);   // R6
      dir_frame(4, 0, 0, 0, 255);   // R7
      dir_frame(5, 0, 0, 40, 166);  // R8 bounds exclusive
      dir_frame(5, 0, 0, 128, 129); // R8 empty window
      dir_frame(6, 0, 0, 0, 255);   // R9 hump
      dir_frame(7, 0, 0, 0, 255);   // R9 bowl
      dir_frame(4, 0, 1, 0, 255);   // R10 grey stretch
      dir_frame(6, 1, 1, 0, 255);   // R10 grey hump

      // constrained random frames with gaps and noisy settings inputs
      for (int f = 0; f < 40; f++) begin
         int mode, dim, gray, lo, hi;
         mode = int'($urandom_range(0, 7));
         dim  = int'($urandom_range(0, 1));
         gray = ($urandom_range(0, 3) == 0) ? 1 : 0;
         lo   = int'($urandom_range(0, 200));
         hi   = lo + int'($urandom_range(0, 55));
         step(1, 1, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
              int'($urandom_range(0, 255)), mode, dim, gray, lo, hi);
         for (int p = 0; p < 50; p++) begin
            bit v;
            v = ($urandom_range(0, 3) != 0);
            step(v, ($urandom_range(0, 9) == 0) && !v,
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
         end
      end

      for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      finish_run();
   end

endmodule